// File: doc/BRIEF.md
# Serial Bus Message-Length Field Sequencer

This block runs the byte-count phase of a frame for the master station on a shared, wired serial bus. A bit-slot timer outside the block supplies one strobe per bit. For each slot the block presents the level the master puts on the bus and samples the level seen on it. A start pulse begins the phase. Along with the start pulse come the broadcast flag, the transfer direction taken from the control field (1 = master sends, 0 = master receives), a two-bit communication mode and the requested byte count.

When the master sends, the block shifts out the eight-bit length code, then an even parity bit. It then releases the bus for the acknowledge slot and decides from the sampled level whether the frame goes on. When the master receives, the block releases the bus while a slave supplies the code and the parity. It checks both, and answers in the acknowledge slot. The result is a one-cycle done pulse with a 9-bit byte count for the following data-field logic, or a one-cycle pulse that sends the master back to monitoring the bus. A start with a count that the mode does not allow is refused with a range-error pulse.

Top module: `lenseq_top`

## Requirements
- R1: After synchronous reset the block is idle, `txBit` is 1 (bus released), `doneOut`, `monitorOut` and `rangeErr` are 0 and `xferCount` is 0.
- R2: In a send frame the eight length-code bits are driven on `txBit` one per slot, most significant first. The code is the low eight bits of the requested count. Each bit is valid before its strobe.
- R3: In a send frame, slot 9 carries even parity: the XOR of the eight code bits.
- R4: In a send frame the master drives 1 during slot 10 (the acknowledge slot). If the frame is not broadcast, a sampled 0 gives `doneOut` and a sampled 1 gives `monitorOut`.
- R5: In a broadcast send frame the acknowledge level is not checked, and the frame always ends with `doneOut`.
- R6: The count allowed is 1..16 in mode 0, 1..32 in mode 1 and 1..128 in mode 2. Mode 3 is reserved. A start in mode 3, or a send start with a count outside the limit, pulses `rangeErr` in the next cycle. No frame begins in that case, and `txBit` stays 1.
- R7: In a receive frame the master drives 1 during slots 1 to 9 and captures the code most significant first. Code 0x00 decodes to 256, and codes 0x01..0xFF decode to 1..255.
- R8: In a receive frame the master drives 0 in the acknowledge slot and ends with `doneOut` only when two conditions hold: the received parity makes the nine bits even, and the decoded count is within the mode limit. Otherwise it drives 1 and ends with `monitorOut`.
- R9: A start pulse that arrives while a frame is in progress is ignored. The serialized bits, the direction and the result of that frame are unchanged.
- R10: `doneOut`, `monitorOut` and `rangeErr` are one-cycle pulses and never coincide. The outcome pulse comes in the cycle after the tenth strobe. `xferCount` (1..256) is valid from the cycle of `doneOut` and holds until the next completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Start pulse for the length phase |
| bcastIn | input | 1 | Frame is a broadcast |
| masterTxIn | input | 1 | 1 = master sends the length, 0 = master receives it |
| modeIn | input | 2 | Communication mode 0..2 (3 reserved) |
| lenCountIn | input | 9 | Requested byte count for a send frame |
| slotStrobe | input | 1 | One-cycle pulse marking each bit slot |
| rxBit | input | 1 | Bus level sampled for the current slot |
| txBit | output | 1 | Level the master drives (1 = released) |
| xferCount | output | 9 | Decoded transfer count of the last completed frame |
| doneOut | output | 1 | Phase finished, move to the next field |
| monitorOut | output | 1 | Phase aborted, return to monitoring |
| rangeErr | output | 1 | Start refused, count or mode out of range |

## Verification
The assertions assume three things. `slotStrobe` lasts one cycle and arrives only after `txBit` for that slot has settled. `startIn` is a single-cycle pulse. The frame inputs stay steady during the start cycle. The stimulus drives every input at the falling edge. It keeps the strobe high for one cycle with at least one idle cycle between strobes, and pulses start only for one cycle. In send frames it echoes the master's own bit onto `rxBit`, so the bus looks free of conflict and the acknowledge slot is the only place where the sampled level differs.

// File: rtl/lenseq_pkg.sv
package lenseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEN  = 2'd1,
    PH_PAR  = 2'd2,
    PH_ACK  = 2'd3
  } phase_e;

  // control -> datapath
  typedef struct packed {
    phase_e phase;
    logic   load;
    logic   shift;
    logic   parSample;
    logic   finishOk;
  } seqStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic dirTx;
    logic bcast;
    logic parBad;
    logic rxRangeOk;
    logic startOk;
  } dpStatus_t;

endpackage

// File: rtl/lenseq_dp.sv
module lenseq_dp
  import lenseq_pkg::*;
#(
  parameter int LEN_BITS = 8,
  parameter int MAX_M0   = 16,
  parameter int MAX_M1   = 32,
  parameter int MAX_M2   = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  seqStrobes_t         strobes,
  input  logic                masterTxIn,
  input  logic                bcastIn,
  input  logic [1:0]          modeIn,
  input  logic [LEN_BITS:0]   lenCountIn,
  input  logic                rxBit,
  output dpStatus_t           status,
  output logic                txBit,
  output logic [LEN_BITS:0]   xferCount
);

  localparam int CNT_W = LEN_BITS + 1;
  localparam int FULL  = 1 << LEN_BITS;

  logic [LEN_BITS-1:0] shReg;
  logic [CNT_W-1:0]    reqCount;
  logic [1:0]          modeQ;
  logic                dirTxQ;
  logic                bcastQ;
  logic                parAcc;
  logic                parBadQ;
  logic [CNT_W-1:0]    rxCount;
  logic                rxRangeOk;
  logic                startOk;

  function automatic logic [CNT_W-1:0] limitFor(input logic [1:0] m);
    case (m)
      2'd0:    limitFor = CNT_W'(MAX_M0);
      2'd1:    limitFor = CNT_W'(MAX_M1);
      2'd2:    limitFor = CNT_W'(MAX_M2);
      default: limitFor = '0;
    endcase
  endfunction

  // received code: all-zero stands for the full 2**LEN_BITS
  assign rxCount   = (shReg == '0) ? CNT_W'(FULL) : {1'b0, shReg};
  assign rxRangeOk = (rxCount <= limitFor(modeQ));
  assign startOk   = (modeIn != 2'd3) &&
                     (!masterTxIn || ((lenCountIn != '0) && (lenCountIn <= limitFor(modeIn))));

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg     <= '0;
      reqCount  <= '0;
      modeQ     <= '0;
      dirTxQ    <= 1'b0;
      bcastQ    <= 1'b0;
      parAcc    <= 1'b0;
      parBadQ   <= 1'b0;
      xferCount <= '0;
    end else begin
      if (strobes.load) begin
        shReg    <= lenCountIn[LEN_BITS-1:0];
        reqCount <= lenCountIn;
        modeQ    <= modeIn;
        dirTxQ   <= masterTxIn;
        bcastQ   <= bcastIn;
        parAcc   <= 1'b0;
        parBadQ  <= 1'b0;
      end
      if (strobes.shift) begin
        parAcc <= parAcc ^ (dirTxQ ? shReg[LEN_BITS-1] : rxBit);
        shReg  <= {shReg[LEN_BITS-2:0], rxBit};
      end
      if (strobes.parSample) begin
        parBadQ <= parAcc ^ rxBit;
      end
      if (strobes.finishOk) begin
        xferCount <= dirTxQ ? reqCount : rxCount;
      end
    end
  end

  always_comb begin
    unique case (strobes.phase)
      PH_LEN:  txBit = dirTxQ ? shReg[LEN_BITS-1] : 1'b1;
      PH_PAR:  txBit = dirTxQ ? parAcc : 1'b1;
      PH_ACK:  txBit = dirTxQ ? 1'b1 : !(!parBadQ && rxRangeOk);
      default: txBit = 1'b1;
    endcase
  end

  assign status = '{dirTx: dirTxQ, bcast: bcastQ, parBad: parBadQ,
                    rxRangeOk: rxRangeOk, startOk: startOk};

  // R1: bus released while idle
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    strobes.phase == PH_IDLE |-> txBit);
  // R4: sending master never pulls the acknowledge slot
  a_r4_tx_ack_released: assert property (@(posedge clk) disable iff (rst)
    (strobes.phase == PH_ACK && dirTxQ) |-> txBit);
  // R7: receiving master leaves code and parity slots to the slave
  a_r7_rx_released: assert property (@(posedge clk) disable iff (rst)
    ((strobes.phase == PH_LEN || strobes.phase == PH_PAR) && !dirTxQ) |-> txBit);
  // R10: a loaded count is always a legal byte count
  a_r10_count_legal: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.finishOk) |-> (xferCount != '0 && xferCount <= CNT_W'(FULL)));

endmodule

// File: rtl/lenseq_ctrl.sv
module lenseq_ctrl
  import lenseq_pkg::*;
#(
  parameter int LEN_BITS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startIn,
  input  logic        slotStrobe,
  input  logic        rxBit,
  input  dpStatus_t   status,
  output seqStrobes_t strobes,
  output logic        doneOut,
  output logic        monitorOut,
  output logic        rangeErr
);

  localparam int CW = $clog2(LEN_BITS);

  phase_e        state;
  logic [CW-1:0] bitCnt;
  logic          ackGood;

  assign ackGood = status.dirTx ? (status.bcast || !rxBit)
                                : (!status.parBad && status.rxRangeOk);

  always_comb begin
    strobes.phase     = state;
    strobes.load      = (state == PH_IDLE) && startIn && status.startOk;
    strobes.shift     = (state == PH_LEN) && slotStrobe;
    strobes.parSample = (state == PH_PAR) && slotStrobe;
    strobes.finishOk  = (state == PH_ACK) && slotStrobe && ackGood;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PH_IDLE;
      bitCnt     <= '0;
      doneOut    <= 1'b0;
      monitorOut <= 1'b0;
      rangeErr   <= 1'b0;
    end else begin
      doneOut    <= 1'b0;
      monitorOut <= 1'b0;
      rangeErr   <= 1'b0;
      unique case (state)
        PH_IDLE: if (startIn) begin
          if (status.startOk) begin
            state  <= PH_LEN;
            bitCnt <= '0;
          end else begin
            rangeErr <= 1'b1;
          end
        end
        PH_LEN: if (slotStrobe) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CW'(LEN_BITS - 1)) state <= PH_PAR;
        end
        PH_PAR: if (slotStrobe) state <= PH_ACK;
        PH_ACK: if (slotStrobe) begin
          doneOut    <= ackGood;
          monitorOut <= !ackGood;
          state      <= PH_IDLE;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  // R10: outcomes are exclusive single-cycle pulses
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({doneOut, monitorOut, rangeErr}));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);
  a_r10_after_strobe: assert property (@(posedge clk) disable iff (rst)
    (doneOut || monitorOut) |-> $past(slotStrobe));
  // R6: a refusal only answers a start seen while idle
  a_r6_err_from_start: assert property (@(posedge clk) disable iff (rst)
    rangeErr |-> ($past(startIn) && $past(state == PH_IDLE)));
  // R4: directed, non-broadcast: acknowledge level decides the outcome
  a_r4_ack_decides: assert property (@(posedge clk) disable iff (rst)
    (state == PH_ACK && slotStrobe && status.dirTx && !status.bcast) |=> (doneOut == !$past(rxBit)));
  // R5: broadcast send always completes
  a_r5_bcast_done: assert property (@(posedge clk) disable iff (rst)
    (state == PH_ACK && slotStrobe && status.dirTx && status.bcast) |=> doneOut);

endmodule

// File: rtl/lenseq_top.sv
module lenseq_top
  import lenseq_pkg::*;
#(
  parameter int LEN_BITS = 8,
  parameter int MAX_M0   = 16,
  parameter int MAX_M1   = 32,
  parameter int MAX_M2   = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic              bcastIn,
  input  logic              masterTxIn,
  input  logic [1:0]        modeIn,
  input  logic [LEN_BITS:0] lenCountIn,
  input  logic              slotStrobe,
  input  logic              rxBit,
  output logic              txBit,
  output logic [LEN_BITS:0] xferCount,
  output logic              doneOut,
  output logic              monitorOut,
  output logic              rangeErr
);

  seqStrobes_t strobes;
  dpStatus_t   status;

  lenseq_ctrl #(.LEN_BITS(LEN_BITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startIn    (startIn),
    .slotStrobe (slotStrobe),
    .rxBit      (rxBit),
    .status     (status),
    .strobes    (strobes),
    .doneOut    (doneOut),
    .monitorOut (monitorOut),
    .rangeErr   (rangeErr)
  );

  lenseq_dp #(
    .LEN_BITS (LEN_BITS),
    .MAX_M0   (MAX_M0),
    .MAX_M1   (MAX_M1),
    .MAX_M2   (MAX_M2)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .masterTxIn (masterTxIn),
    .bcastIn    (bcastIn),
    .modeIn     (modeIn),
    .lenCountIn (lenCountIn),
    .rxBit      (rxBit),
    .status     (status),
    .txBit      (txBit),
    .xferCount  (xferCount)
  );

endmodule

// File: tb/lenseq_top_bench.sv
module lenseq_top_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startIn = 1'b0;
  logic       bcastIn = 1'b0;
  logic       masterTxIn = 1'b1;
  logic [1:0] modeIn = 2'd0;
  logic [8:0] lenCountIn = '0;
  logic       slotStrobe = 1'b0;
  logic       rxBit = 1'b1;
  logic       txBit;
  logic [8:0] xferCount;
  logic       doneOut, monitorOut, rangeErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lenseq_top u_lenseq_top (
    .clk(clk), .rst(rst), .startIn(startIn), .bcastIn(bcastIn),
    .masterTxIn(masterTxIn), .modeIn(modeIn), .lenCountIn(lenCountIn),
    .slotStrobe(slotStrobe), .rxBit(rxBit), .txBit(txBit),
    .xferCount(xferCount), .doneOut(doneOut), .monitorOut(monitorOut),
    .rangeErr(rangeErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int limitOf(input int m);
    return (m == 0) ? 16 : (m == 1) ? 32 : (m == 2) ? 128 : 0;
  endfunction

  int lastCount = 0;

  task automatic runTx(input int mode, input int cnt, input bit bc, input bit ackLvl, input bit busyPoke);
    logic [7:0] code;
    bit expErr, expDone, par;
    code   = cnt[7:0];
    par    = ^code;
    expErr = (mode == 3) || (cnt < 1) || (cnt > limitOf(mode));
    expDone = bc || (ackLvl == 1'b0);
    masterTxIn = 1'b1; bcastIn = bc; modeIn = mode[1:0]; lenCountIn = cnt[8:0];
    startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
    if (expErr) begin
      check(rangeErr == 1'b1, "R6 refusal pulse", rangeErr, 1);
      check(txBit == 1'b1, "R6 bus stays released", txBit, 1);
      @(negedge clk);
      check(rangeErr == 1'b0, "R10 refusal one cycle", rangeErr, 0);
      return;
    end
    check(rangeErr == 1'b0, "R6 legal start accepted", rangeErr, 0);
    for (int k = 0; k < 10; k++) begin
      bit expTx;
      expTx = (k < 8) ? code[7-k] : (k == 8) ? par : 1'b1;
      if (k < 8) check(txBit == expTx, (busyPoke && k > 3) ? "R9 bits unchanged" : "R2 code bit", txBit, expTx);
      else if (k == 8) check(txBit == expTx, "R3 parity bit", txBit, expTx);
      else check(txBit == 1'b1, "R4 ack slot released", txBit, 1);
      rxBit = (k == 9) ? ackLvl : expTx;
      slotStrobe = 1'b1;
      if (busyPoke && k == 3) begin
        startIn = 1'b1; masterTxIn = 1'b0; lenCountIn = 9'd0; modeIn = 2'd3;
      end
      @(negedge clk);
      slotStrobe = 1'b0; startIn = 1'b0;
      masterTxIn = 1'b1; lenCountIn = cnt[8:0]; modeIn = mode[1:0];
      if (k < 9) @(negedge clk);
    end
    if (bc) check(doneOut == 1'b1, "R5 broadcast completes", doneOut, 1);
    else if (expDone) check(doneOut == 1'b1 && monitorOut == 1'b0, "R4 ack gives done", doneOut, 1);
    else check(monitorOut == 1'b1 && doneOut == 1'b0, "R4 no ack gives monitor", monitorOut, 1);
    if (busyPoke) check(rangeErr == 1'b0, "R9 busy start no effect", rangeErr, 0);
    if (expDone) begin
      check(xferCount == cnt[8:0], "R10 count at done", xferCount, cnt);
      lastCount = cnt;
    end else begin
      check(xferCount == lastCount[8:0], "R10 count held", xferCount, lastCount);
    end
    @(negedge clk);
    check(!doneOut && !monitorOut, "R10 outcome one cycle", {doneOut, monitorOut}, 0);
    check(xferCount == lastCount[8:0], "R10 count stays", xferCount, lastCount);
  endtask

  task automatic runRx(input int mode, input int code, input bit parGood);
    logic [7:0] c;
    int dec;
    bit expOk;
    c = code[7:0];
    dec = (c == 0) ? 256 : code;
    expOk = parGood && (dec <= limitOf(mode));
    masterTxIn = 1'b0; bcastIn = 1'b0; modeIn = mode[1:0]; lenCountIn = 9'd0;
    startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
    if (mode == 3) begin
      check(rangeErr == 1'b1, "R6 reserved mode refused", rangeErr, 1);
      @(negedge clk);
      return;
    end
    for (int k = 0; k < 10; k++) begin
      if (k < 9) begin
        check(txBit == 1'b1, "R7 receive slot released", txBit, 1);
        rxBit = (k < 8) ? c[7-k] : ((^c) ^ !parGood);
      end else begin
        check(txBit == !expOk, "R8 ack level", txBit, !expOk);
        rxBit = !expOk;
      end
      slotStrobe = 1'b1;
      @(negedge clk);
      slotStrobe = 1'b0;
      if (k < 9) @(negedge clk);
    end
    if (expOk) begin
      check(doneOut == 1'b1, "R8 good frame done", doneOut, 1);
      check(xferCount == dec[8:0], "R7 decoded count", xferCount, dec);
      lastCount = dec;
    end else begin
      check(monitorOut == 1'b1 && doneOut == 1'b0, "R8 bad frame monitor", monitorOut, 1);
      check(xferCount == lastCount[8:0], "R10 count held", xferCount, lastCount);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txBit == 1'b1, "R1 reset bus released", txBit, 1);
    check(!doneOut && !monitorOut && !rangeErr, "R1 reset no pulses",
          {doneOut, monitorOut, rangeErr}, 0);
    check(xferCount == 9'd0, "R1 reset count", xferCount, 0);
    for (int m = 0; m < 4; m++)
      for (int n = 0; n < 262; n++)
        runTx(m, n, n[2], (n % 3) == 0, (n % 7) == 3);
    // R7 code 0x00 decodes to 256, beyond every limit
    for (int m = 0; m < 4; m++)
      for (int cd = 0; cd < 256; cd++)
        runRx(m, cd, (cd % 5) != 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule